// File: doc/BRIEF.md
# Burst Transient Capture Recorder

This block works like the memory behind a digital storage oscilloscope. A host arms it and picks a record length. It waits for a trigger and then stores converter samples at whatever rate the sample strobe sets. Once the record is full, it plays the stored words back slowly over a ready/valid byte interface, for example into a serial transmitter. Recording and playback never overlap. The fast side only writes and the slow side only reads, so the converter side is never throttled by the host.

Each stored word is cut into bytes, most significant byte first. A byte moves only in a cycle where valid and ready are both high. The first sample captured is the first one delivered. A busy flag covers the whole cycle from arm to the last accepted byte. A one-cycle done pulse marks the end of playback. The block takes a new arm in that same done cycle, so back-to-back bursts separated by a short gap can be recorded.

Top module: `trec_recorder`

## Requirements
- R1: After reset `busy`, `out_valid` and `done` are low.
- R2: An `arm` pulse while idle is accepted. `busy` is high from the next cycle. `arm_long` sampled with it selects the record length: 1 gives 512 words, 0 gives 256 words.
- R3: Sample strobes are ignored while idle and while armed but not yet triggered. None of those values appears in the playback.
- R4: `trig` while armed starts recording from the next cycle. Each strobe after that stores one word. After the strobe that fills the record, `out_valid` is high from the next cycle.
- R5: Playback is first-in-first-out. Words come out in the order they were captured, and exactly the selected number of words is delivered.
- R6: Each 16-bit word is sent as two bytes, bits 15..8 first, then bits 7..0. The byte advances only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R7: `arm` while armed, recording or playing back is refused. It does not change the record length or restart the cycle, including an `arm` in the cycle of the final byte transfer.
- R8: `busy` stays high until the last byte is accepted and is low from the next cycle.
- R9: `done` is high for exactly one cycle: the cycle after the final byte transfer.
- R10: An `arm` in the cycle in which `done` is high is accepted and starts a new record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample strobe from the converter |
| smp_data | input | 16 | Sample word |
| arm | input | 1 | Arm request pulse |
| arm_long | input | 1 | Record length select sampled with arm (1 = 512, 0 = 256) |
| trig | input | 1 | Trigger |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Playback byte |
| out_valid | output | 1 | Playback byte valid |
| done | output | 1 | One-cycle end-of-playback pulse |
| busy | output | 1 | Armed, recording or playing back |

## Verification
The bench targets the cycle in which the final byte is handed over. In that cycle the refusal of a new arm (R7) meets the end of playback (R8, R9). The bench raises `arm`, with the opposite length select, exactly on that handshake. It then raises `arm` again in the following done cycle. The first request must leave no trace: `busy` falls and `done` pulses exactly as the reference model predicts. The second request must be taken, and the record it starts must have the length chosen in the done cycle. Its word count and content are checked against the model.

// File: rtl/trec_pkg.sv
// Shared types for the transient recorder.
package trec_pkg;
    // Phases of the one-shot record-then-dump cycle.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_DUMP    = 2'd3
    } trec_state_e;
endpackage

// File: rtl/trec_fsm.sv
// Phase controller. Moves idle -> armed -> capture -> dump -> idle.
// Latches the record length when an arm is accepted and raises done
// for one cycle after the final byte transfer.
// Assumes wr_last and rd_last are single-cycle qualifiers from the
// counters and can only be high in capture and dump respectively.
module trec_fsm
    import trec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        arm_long,
    input  logic        trig,
    input  logic        wr_last,
    input  logic        rd_last,
    output trec_state_e state,
    output logic        len_long,
    output logic        start,
    output logic        done
);
    // Arm is taken only in idle; every other phase refuses it.
    assign start = (state == ST_IDLE) && arm;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (start)   state <= ST_ARMED;
                ST_ARMED:   if (trig)    state <= ST_CAPTURE;
                ST_CAPTURE: if (wr_last) state <= ST_DUMP;
                ST_DUMP:    if (rd_last) state <= ST_IDLE;
                default:                 state <= ST_IDLE;
            endcase
        end
    end

    // Record length, captured with the accepted arm.
    always_ff @(posedge clk) begin
        if (!rst_n)     len_long <= 1'b0;
        else if (start) len_long <= arm_long;
    end

    // End-of-playback pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= rd_last;
    end
endmodule

// File: rtl/trec_wcount.sv
// Write address counter. Advances once per stored sample and flags
// the sample that fills the selected record length.
// Assumes clear and en are never high together.
module trec_wcount #(
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 512,
    localparam int AW       = $clog2(LONG_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic          len_long,
    output logic [AW-1:0] waddr,
    output logic          wr_last
);
    localparam logic [AW-1:0] LAST_SHORT = AW'(SHORT_LEN - 1);
    localparam logic [AW-1:0] LAST_LONG  = AW'(LONG_LEN - 1);

    logic [AW-1:0] last_idx;

    // Index of the final word for the latched length.
    assign last_idx = len_long ? LAST_LONG : LAST_SHORT;
    assign wr_last  = en && (waddr == last_idx);

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n)     waddr <= '0;
        else if (clear) waddr <= '0;
        else if (en)    waddr <= waddr + 1'b1;
    end
endmodule

// File: rtl/trec_readout.sv
// Sample store and byte-wise playback. Words are written at the
// write address and read back from address zero upward, each word
// split into bytes from the most significant end.
// Assumes DATA_W is a multiple of BYTE_W and that writes and the
// dumping phase never overlap.
module trec_readout #(
    parameter int DATA_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 512,
    localparam int AW       = $clog2(LONG_LEN),
    localparam int BPW      = DATA_W / BYTE_W,
    localparam int BSW      = (BPW > 1) ? $clog2(BPW) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear,
    input  logic              dumping,
    input  logic              len_long,
    input  logic              ready,
    output logic [BYTE_W-1:0] data,
    output logic              valid,
    output logic              rd_last
);
    localparam logic [AW-1:0]  LAST_SHORT = AW'(SHORT_LEN - 1);
    localparam logic [AW-1:0]  LAST_LONG  = AW'(LONG_LEN - 1);
    localparam logic [BSW-1:0] LAST_BYTE  = BSW'(BPW - 1);

    logic [DATA_W-1:0] mem [LONG_LEN];
    logic [AW-1:0]     raddr;
    logic [BSW-1:0]    bsel;
    logic [DATA_W-1:0] rd_word;
    logic              fire;
    logic              word_end;
    logic [AW-1:0]     last_idx;

    assign valid    = dumping;
    assign fire     = valid && ready;
    assign word_end = (bsel == LAST_BYTE);
    assign last_idx = len_long ? LAST_LONG : LAST_SHORT;
    assign rd_last  = fire && word_end && (raddr == last_idx);
    assign rd_word  = mem[raddr];

    // Sample storage write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Byte select: wraps to the top byte after each word.
    always_ff @(posedge clk) begin
        if (!rst_n)     bsel <= '0;
        else if (clear) bsel <= '0;
        else if (fire)  bsel <= word_end ? '0 : bsel + 1'b1;
    end

    // Read address: advances after the last byte of a word.
    always_ff @(posedge clk) begin
        if (!rst_n)                 raddr <= '0;
        else if (clear)             raddr <= '0;
        else if (fire && word_end)  raddr <= raddr + 1'b1;
    end

    // Byte mux, most significant byte at select zero.
    always_comb begin
        data = '0;
        for (int k = 0; k < BPW; k++) begin
            if (bsel == BSW'(k)) data = rd_word[DATA_W-1-k*BYTE_W -: BYTE_W];
        end
    end
endmodule

// File: rtl/trec_recorder.sv
// Burst transient capture recorder, top level. Arm with a length
// select, trigger, record strobed samples, then play them back as
// bytes over ready/valid. Busy covers arm to last accepted byte.
// Assumes the strobe rate never exceeds one sample per clock.
module trec_recorder
    import trec_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BYTE_W    = 8,
    parameter int SHORT_LEN = 256,
    parameter int LONG_LEN  = 512,
    localparam int AW       = $clog2(LONG_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              arm,
    input  logic              arm_long,
    input  logic              trig,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    output logic              done,
    output logic              busy
);
    trec_state_e   state;
    logic          len_long;
    logic          start;
    logic          wr_en;
    logic          wr_last;
    logic          rd_last;
    logic [AW-1:0] waddr;

    // Strobes count only while recording.
    assign wr_en = (state == ST_CAPTURE) && smp_stb;
    assign busy  = (state != ST_IDLE);

    trec_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .arm_long (arm_long),
        .trig     (trig),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .state    (state),
        .len_long (len_long),
        .start    (start),
        .done     (done)
    );

    trec_wcount #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_wcount (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .en       (wr_en),
        .len_long (len_long),
        .waddr    (waddr),
        .wr_last  (wr_last)
    );

    trec_readout #(
        .DATA_W    (DATA_W),
        .BYTE_W    (BYTE_W),
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN)
    ) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .waddr    (waddr),
        .wdata    (smp_data),
        .clear    (start),
        .dumping  (state == ST_DUMP),
        .len_long (len_long),
        .ready    (out_ready),
        .data     (out_data),
        .valid    (out_valid),
        .rd_last  (rd_last)
    );
endmodule

// File: rtl/trec_recorder_chk.sv
// Port-level protocol checker for the recorder, bound to every instance.
module trec_recorder_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_valid,
    input logic              done,
    input logic              busy
);
    AST_ARM_TAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && arm) |=> busy); // R2

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

    AST_VALID_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R8

    AST_BUSY_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) && !busy && !out_valid)); // R9
endmodule

bind trec_recorder trec_recorder_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .done      (done),
    .busy      (busy)
);

// File: tb/trec_recorder_test.sv
// Bench: behavioural queue model compared every cycle, plus record-level checks.
module trec_recorder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] smp_data = '0;
    logic        arm = 1'b0;
    logic        arm_long = 1'b0;
    logic        trig = 1'b0;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        done;
    logic        busy;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    trec_recorder uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .smp_data  (smp_data),
        .arm       (arm),
        .arm_long  (arm_long),
        .trig      (trig),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_valid (out_valid),
        .done      (done),
        .busy      (busy)
    );

    // ---------------- reference model ----------------
    int          m_st = 0;     // 0 idle, 1 armed, 2 recording, 3 playback
    int          m_len = 256;
    int          m_byte = 0;
    bit          m_done = 1'b0;
    logic [15:0] m_q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_done = 1'b0; m_byte = 0; m_q.delete();
        end else begin
            m_done = 1'b0;
            case (m_st)
                0: if (arm) begin
                       m_len = arm_long ? 512 : 256; m_q.delete(); m_byte = 0; m_st = 1;
                   end
                1: if (trig) m_st = 2;
                2: if (smp_stb) begin
                       m_q.push_back(smp_data);
                       if (m_q.size() == m_len) m_st = 3;
                   end
                default: if (out_ready) begin
                       if (m_byte == 0) m_byte = 1;
                       else begin
                           m_byte = 0;
                           void'(m_q.pop_front());
                           if (m_q.size() == 0) begin m_st = 0; m_done = 1'b1; end
                       end
                   end
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            logic [15:0] w;
            logic [7:0]  eb;
            check(busy == (m_st != 0), "R8", "busy", busy, m_st != 0);
            check(out_valid == (m_st == 3), "R4", "out_valid", out_valid, m_st == 3);
            check(done == m_done, "R9", "done", done, m_done);
            if (m_st == 3 && m_q.size() > 0) begin
                w  = m_q[0];
                eb = (m_byte == 0) ? w[15:8] : w[7:0];
                check(out_data == eb, "R6", "out_data", out_data, eb);
            end
        end
    end

    task automatic finish_run();
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic logic [15:0] wv(input int rec, input int n);
        return 16'(n * 37 + rec * 4099 + 16'h1357);
    endfunction

    function automatic bit rdy_pat(input int mode, input int c);
        if (mode == 0) return 1'b1;
        if (mode == 1) return (c % 3) != 0;
        return (c % 4) == 0;
    endfunction

    // One complete record: optional arm, ignored strobes, trigger,
    // capture, playback with byte assembly, then optional chained arm.
    task automatic run_record(input bit long_sel, input int stb_div, input int rdy_mode,
                              input int rec, input bit preset, input bit chain,
                              input bit next_long);
        int          len = long_sel ? 512 : 256;
        int          n = 0;
        int          cyc = 0;
        int          hs = 0;
        int          bad = -1;
        logic [7:0]  hi = '0;
        logic [15:0] got[$];
        if (!preset) begin
            @(negedge clk); arm = 1'b1; arm_long = long_sel;
            @(negedge clk); arm = 1'b0;
        end
        // R3: strobes while armed, before trigger, carry a marker value.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); smp_stb = 1'b1; smp_data = 16'hDEAD;
        end
        @(negedge clk); smp_stb = 1'b0; trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        // R4: capture; R7: refused arm with opposite length mid-record.
        while (n < len) begin
            smp_stb  = (cyc % stb_div) == 0;
            smp_data = smp_stb ? wv(rec, n) : 16'hBEEF;
            arm      = (cyc == 10);
            arm_long = (cyc == 10) ? ~long_sel : arm_long;
            if (smp_stb) n++;
            cyc++;
            @(negedge clk);
        end
        smp_stb = 1'b0; arm = 1'b0;
        // Playback.
        cyc = 0;
        while (hs < 2 * len) begin
            out_ready = rdy_pat(rdy_mode, cyc);
            arm = 1'b0;
            if (hs == 20) begin arm = 1'b1; arm_long = ~long_sel; end   // R7
            if (out_valid && out_ready) begin
                if (hs == 2 * len - 1) begin arm = 1'b1; arm_long = ~long_sel; end // R7 same cycle
                if ((hs % 2) == 0) hi = out_data;
                else got.push_back({hi, out_data});
                hs++;
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        check(done == 1'b1, "R9", "done after last byte", done, 1);
        check(busy == 1'b0, "R8", "busy after last byte", busy, 0);
        check(got.size() == len, "R2", "word count", got.size(), len);
        if (got.size() > 0) check(got[0] == wv(rec, 0), "R3", "first word", got[0], wv(rec, 0));
        for (int i = 0; i < got.size() && i < len; i++)
            if (bad < 0 && got[i] != wv(rec, i)) bad = i;
        check(bad < 0, "R5", "fifo order index", bad, -1);
        // R10: arm in the done cycle.
        arm = chain; arm_long = next_long;
        @(negedge clk); arm = 1'b0;
        check(busy == chain, "R10", "busy after done-cycle arm", busy, chain);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(busy == 1'b0, "R1", "busy at reset", busy, 0);
        check(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
        check(done == 1'b0, "R1", "done at reset", done, 0);
        cmp_en = 1'b1;
        // R3: strobes while idle.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); smp_stb = 1'b1; smp_data = 16'hDEAD;
        end
        @(negedge clk); smp_stb = 1'b0;
        check(busy == 1'b0, "R3", "idle strobes leave block idle", busy, 0);
        run_record(1'b0, 2, 0, 1, 1'b0, 1'b0, 1'b0);
        run_record(1'b1, 1, 1, 2, 1'b0, 1'b1, 1'b0);
        run_record(1'b0, 3, 2, 3, 1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule